// File: doc/BRIEF.md
# OTP Fuse Controller Register Interface

This block is the register-side front end of a one-time-programmable fuse array. It keeps a shadow copy of every fuse word that software reads over a simple word-addressed register bus. It also presents a control word with bit-set and bit-clear aliases and a write-data register. Burning a fuse word or refreshing the shadows is handed to an external fuse sequencer. The block talks to it through a one-cycle request pulse and a one-cycle done pulse. Each request covers one word: either a program with data or a read that returns data.

A program is armed by writing the target word address and the 16-bit unlock key into the control word. The program starts when the data register is written next. The key is consumed by that attempt, and the target address and data are frozen until the sequencer reports completion. Per-word protection comes from a dedicated lock word, which is the highest fuse word. It is loaded into the block whenever the shadows are reloaded. A refused access never reaches the fuses. Instead it raises a sticky error flag, and the block then rejects further requests until software clears the flag.

Top module: `fuse_ctl_regs`

## Requirements
- R1: After reset the control word, the data register and every shadow word read as 0, and no word is locked.
- R2: The control word sits at byte offset 0x000 and is laid out as follows: word address in bits [7:0], busy in bit 8, error in bit 9, reload in bit 10, and the unlock key 0x3E77 in bits [31:16] while armed. A write at 0x000 replaces the address and arms the key only if bits [31:16] equal 0x3E77, and disarms it otherwise. A write at 0x004 ORs into the address and can only arm the key. A write at 0x008 clears the address bits given. All three offsets read back the control word.
- R3: Writing the data register (offset 0x020) while the key is not armed only stores the data and issues no program request.
- R4: Writing the data register while armed, idle and error-free sets busy, disarms the key and latches the address. Address writes made afterwards do not change the word being programmed. Busy clears once the sequencer signals done.
- R5: While busy, a data register write leaves the data register unchanged and sets error.
- R6: An armed data write whose address is write-locked, or is not below the word count, issues no sequencer request and does not set busy. It sets error and disarms the key.
- R7: Writing bit 10 to offset 0x000 or 0x004 starts a reload that reads every fuse word in turn into its shadow. During the reload, bits 8 and 10 read 1, and both clear by themselves at the end. Reloading the highest word also loads the lock word, whose bit n write-locks word n and whose bit 16+n read-locks word n.
- R8: Reading a read-locked shadow returns 0xBADABADA and sets error.
- R9: Shadow word n sits at offset 0x400 + 16*n and can be written when idle and unlocked. A shadow write during a reload, or to a write-locked word, sets error and leaves the shadow unchanged.
- R10: While error is set, data writes, reload requests and shadow writes are ignored, and shadow reads return 0xBADABADA. Writing bit 9 to offset 0x008 clears error.
- R11: A program changes only the fuse and not the shadow; the new value appears in the shadow after the next reload.
- R12: A reload request or shadow access made while busy is not carried out and sets error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe |
| busAddr | input | BUS_AW | Byte offset of the access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid with busRvalid |
| busRvalid | output | 1 | One-cycle pulse, one cycle after busRe |
| seqReq | output | 1 | One-cycle request pulse to the fuse sequencer |
| seqOp | output | 1 | Operation of the request: 0 program, 1 read |
| seqAddr | output | IDX_W | Fuse word index, stable until done |
| seqWdata | output | DATA_W | Program data, stable until done |
| seqDone | input | 1 | One-cycle completion pulse |
| seqRdata | input | DATA_W | Fuse word returned with seqDone on a read |

## Verification
The program path is exercised in four situations: a data write without the key, an armed write to a free word, an armed write to a locked word, and an armed write to an address outside the array. These separate key gating from lock checking and from range checking. Reloads are started through the set alias from a clean state, with a shadow write racing the reload, and with a program in flight. Together these show that the reload result, the lock-word load and the busy rejection are distinct effects. Shadow reads and writes are repeated across unlocked, read-locked, write-locked and error-pending words. This shows that the sentinel comes from the lock and also from the pending error.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;

  localparam logic [15:0] UNLOCK_KEY  = 16'h3E77;
  localparam logic [31:0] LOCKED_WORD = 32'hBADA_BADA;

  localparam int CTRL_ADDR_W = 8;
  localparam int BUSY_BIT    = 8;
  localparam int ERR_BIT     = 9;
  localparam int RELOAD_BIT  = 10;

  localparam int OFS_CTRL    = 'h000;
  localparam int OFS_SET     = 'h004;
  localparam int OFS_CLR     = 'h008;
  localparam int OFS_DATA    = 'h020;
  localparam int OFS_SHADOW  = 'h400;
  localparam int SHADOW_STEP = 'h10;

  typedef enum logic [1:0] {CW_WRITE, CW_SET, CW_CLR} ctrl_mode_e;
  typedef enum logic [2:0] {RS_ZERO, RS_CTRL, RS_DATA, RS_SHADOW, RS_LOCKED} rd_sel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_RELOAD} seq_state_e;

  typedef struct packed {
    logic       ctrlWr;
    ctrl_mode_e ctrlMode;
    logic       dataWr;
    logic       launch;
    logic       clrUnlock;
    logic       setErr;
    logic       clrErr;
    logic       shWr;
    logic       fuseLoad;
    logic       rdEn;
    rd_sel_e    rdSel;
  } dp_stb_t;

endpackage

// File: rtl/fuse_ctl_ctrl.sv
module fuse_ctl_ctrl
  import fuse_ctl_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int BUS_AW    = 12,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWe,
  input  logic                   busRe,
  input  logic [BUS_AW-1:0]      busAddr,
  input  logic                   reloadBit,
  input  logic                   errBit,
  input  logic                   seqDone,
  input  logic [CTRL_ADDR_W-1:0] ctrlAddr,
  input  logic                   unlocked,
  input  logic                   errFlag,
  input  logic [NUM_WORDS-1:0]   wrLock,
  input  logic [NUM_WORDS-1:0]   rdLock,
  input  logic [IDX_W-1:0]       opAddr,
  output dp_stb_t                stb,
  output logic [IDX_W-1:0]       shIdx,
  output logic [IDX_W-1:0]       reloadIdx,
  output logic                   busy,
  output logic                   reloading,
  output logic                   seqReq,
  output logic                   seqOp,
  output logic [IDX_W-1:0]       seqAddr
);

  localparam int SH_END = OFS_SHADOW + NUM_WORDS * SHADOW_STEP;

  seq_state_e stateQ, stateD;
  logic [IDX_W-1:0] idxQ, idxD;
  logic reqQ, reqD;

  logic hitCtrl, hitSet, hitClr, hitData, hitSh, addrOk, startReload;

  assign hitCtrl = busAddr == BUS_AW'(OFS_CTRL);
  assign hitSet  = busAddr == BUS_AW'(OFS_SET);
  assign hitClr  = busAddr == BUS_AW'(OFS_CLR);
  assign hitData = busAddr == BUS_AW'(OFS_DATA);
  assign hitSh   = (busAddr >= BUS_AW'(OFS_SHADOW)) && (busAddr < BUS_AW'(SH_END))
                   && (busAddr[3:0] == 4'h0);
  assign shIdx   = busAddr[4 +: IDX_W];
  assign addrOk  = ctrlAddr < CTRL_ADDR_W'(NUM_WORDS);

  assign busy      = stateQ != ST_IDLE;
  assign reloading = stateQ == ST_RELOAD;
  assign reloadIdx = idxQ;
  assign seqReq    = reqQ;
  assign seqOp     = reloading;
  assign seqAddr   = reloading ? idxQ : opAddr;

  // Bus decode and request gating
  always_comb begin
    stb         = '0;
    stb.rdSel   = RS_ZERO;
    startReload = 1'b0;
    if (busWe) begin
      if (hitCtrl || hitSet || hitClr) begin
        stb.ctrlWr   = 1'b1;
        stb.ctrlMode = hitClr ? CW_CLR : (hitSet ? CW_SET : CW_WRITE);
        if (hitClr && errBit) stb.clrErr = 1'b1;
        if (!hitClr && reloadBit) begin
          if (busy)          stb.setErr  = 1'b1;
          else if (!errFlag) startReload = 1'b1;
        end
      end else if (hitData) begin
        if (busy) stb.setErr = 1'b1;
        else if (!errFlag) begin
          stb.dataWr = 1'b1;
          if (unlocked) begin
            stb.clrUnlock = 1'b1;
            if (addrOk && !wrLock[ctrlAddr[IDX_W-1:0]]) stb.launch = 1'b1;
            else                                        stb.setErr = 1'b1;
          end
        end
      end else if (hitSh) begin
        if (!errFlag) begin
          if (busy || wrLock[shIdx]) stb.setErr = 1'b1;
          else                       stb.shWr   = 1'b1;
        end
      end
    end else if (busRe) begin
      stb.rdEn = 1'b1;
      if (hitCtrl || hitSet || hitClr) stb.rdSel = RS_CTRL;
      else if (hitData)                stb.rdSel = RS_DATA;
      else if (hitSh) begin
        if (busy || errFlag || rdLock[shIdx]) begin
          stb.rdSel  = RS_LOCKED;
          stb.setErr = 1'b1;
        end else begin
          stb.rdSel  = RS_SHADOW;
        end
      end
    end
    stb.fuseLoad = reloading && seqDone;
  end

  // Operation sequencing
  always_comb begin
    stateD = stateQ;
    idxD   = idxQ;
    reqD   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (stb.launch) begin
          stateD = ST_PROG;
          reqD   = 1'b1;
        end else if (startReload) begin
          stateD = ST_RELOAD;
          idxD   = '0;
          reqD   = 1'b1;
        end
      end
      ST_PROG: if (seqDone) stateD = ST_IDLE;
      ST_RELOAD: begin
        if (seqDone) begin
          if (idxQ == IDX_W'(NUM_WORDS - 1)) begin
            stateD = ST_IDLE;
          end else begin
            idxD = idxQ + 1'b1;
            reqD = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
      reqQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
      reqQ   <= reqD;
    end
  end

endmodule

// File: rtl/fuse_ctl_dp.sv
module fuse_ctl_dp
  import fuse_ctl_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int LOCK_IDX = NUM_WORDS - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dp_stb_t                stb,
  input  logic [DATA_W-1:0]      busWdata,
  input  logic [IDX_W-1:0]       shIdx,
  input  logic [IDX_W-1:0]       reloadIdx,
  input  logic [DATA_W-1:0]      seqRdata,
  input  logic                   busy,
  input  logic                   reloading,
  output logic [CTRL_ADDR_W-1:0] ctrlAddr,
  output logic                   unlocked,
  output logic                   errFlag,
  output logic [NUM_WORDS-1:0]   wrLock,
  output logic [NUM_WORDS-1:0]   rdLock,
  output logic [IDX_W-1:0]       opAddr,
  output logic [DATA_W-1:0]      dataReg,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rdValid
);

  logic [NUM_WORDS-1:0][DATA_W-1:0] shadowFlat;
  logic [2*NUM_WORDS-1:0] lockQ;
  logic [DATA_W-1:0] ctrlWord, rdNext;
  logic keyHit;

  assign keyHit = busWdata[DATA_W-1 -: 16] == UNLOCK_KEY;
  assign wrLock = lockQ[NUM_WORDS-1:0];
  assign rdLock = lockQ[NUM_WORDS +: NUM_WORDS];

  // Control word fields and the program latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlAddr <= '0;
      unlocked <= 1'b0;
      errFlag  <= 1'b0;
      opAddr   <= '0;
      dataReg  <= '0;
    end else begin
      if (stb.ctrlWr) begin
        unique case (stb.ctrlMode)
          CW_WRITE: begin
            ctrlAddr <= busWdata[CTRL_ADDR_W-1:0];
            unlocked <= keyHit;
          end
          CW_SET: begin
            ctrlAddr <= ctrlAddr | busWdata[CTRL_ADDR_W-1:0];
            if (keyHit) unlocked <= 1'b1;
          end
          default: ctrlAddr <= ctrlAddr & ~busWdata[CTRL_ADDR_W-1:0];
        endcase
      end
      if (stb.clrUnlock) unlocked <= 1'b0;
      if (stb.dataWr)    dataReg  <= busWdata;
      if (stb.launch)    opAddr   <= ctrlAddr[IDX_W-1:0];
      if (stb.setErr)      errFlag <= 1'b1;
      else if (stb.clrErr) errFlag <= 1'b0;
    end
  end

  // Shadow words
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_shadow
    logic [DATA_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          wordQ <= '0;
      else if (stb.fuseLoad && reloadIdx == IDX_W'(w))    wordQ <= seqRdata;
      else if (stb.shWr && shIdx == IDX_W'(w))            wordQ <= busWdata;
    end
    assign shadowFlat[w] = wordQ;
  end

  // Lock word, taken from the highest fuse word during reload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockQ <= '0;
    else if (stb.fuseLoad && reloadIdx == IDX_W'(LOCK_IDX))
      lockQ <= seqRdata[2*NUM_WORDS-1:0];
  end

  always_comb begin
    ctrlWord                    = '0;
    ctrlWord[CTRL_ADDR_W-1:0]   = ctrlAddr;
    ctrlWord[BUSY_BIT]          = busy;
    ctrlWord[ERR_BIT]           = errFlag;
    ctrlWord[RELOAD_BIT]        = reloading;
    ctrlWord[DATA_W-1 -: 16]    = unlocked ? UNLOCK_KEY : 16'h0;
  end

  always_comb begin
    unique case (stb.rdSel)
      RS_CTRL:   rdNext = ctrlWord;
      RS_DATA:   rdNext = dataReg;
      RS_SHADOW: rdNext = shadowFlat[shIdx];
      RS_LOCKED: rdNext = LOCKED_WORD;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn) rdata <= rdNext;
    end
  end

endmodule

// File: rtl/fuse_ctl_regs.sv
module fuse_ctl_regs
  import fuse_ctl_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int DATA_W    = 32,
  parameter int BUS_AW    = 12,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic              seqReq,
  output logic              seqOp,
  output logic [IDX_W-1:0]  seqAddr,
  output logic [DATA_W-1:0] seqWdata,
  input  logic              seqDone,
  input  logic [DATA_W-1:0] seqRdata
);

  dp_stb_t stb;
  logic [CTRL_ADDR_W-1:0] ctrlAddr;
  logic unlocked, errFlag, busy, reloading;
  logic [NUM_WORDS-1:0] wrLock, rdLock;
  logic [IDX_W-1:0] opAddr, shIdx, reloadIdx;
  logic [DATA_W-1:0] dataReg;

  assign seqWdata = dataReg;

  fuse_ctl_ctrl #(.NUM_WORDS(NUM_WORDS), .BUS_AW(BUS_AW)) ctrl_i (
    .clk, .rstN, .busWe, .busRe, .busAddr,
    .reloadBit(busWdata[RELOAD_BIT]), .errBit(busWdata[ERR_BIT]),
    .seqDone, .ctrlAddr, .unlocked, .errFlag, .wrLock, .rdLock, .opAddr,
    .stb, .shIdx, .reloadIdx, .busy, .reloading, .seqReq, .seqOp, .seqAddr
  );

  fuse_ctl_dp #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) dp_i (
    .clk, .rstN, .stb, .busWdata, .shIdx, .reloadIdx, .seqRdata, .busy, .reloading,
    .ctrlAddr, .unlocked, .errFlag, .wrLock, .rdLock, .opAddr, .dataReg,
    .rdata(busRdata), .rdValid(busRvalid)
  );

endmodule

// File: rtl/fuse_ctl_chk.sv
module fuse_ctl_chk
  import fuse_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              seqReq,
  input logic              seqOp,
  input logic              unlocked,
  input logic              errFlag,
  input logic [DATA_W-1:0] dataReg,
  input logic              busRvalid,
  input logic [DATA_W-1:0] busRdata
);

  AST_KEY_DROPPED_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !seqOp) |-> !unlocked); // R4

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(dataReg)); // R5

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    seqReq |-> busy); // R7

  AST_SENTINEL_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (busRvalid && busRdata == LOCKED_WORD) |-> errFlag); // R8

  AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && errFlag) |=> !busy); // R10

endmodule

bind fuse_ctl_regs fuse_ctl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk, .rstN, .busy, .seqReq, .seqOp, .unlocked, .errFlag, .dataReg,
  .busRvalid, .busRdata
);

// File: tb/fuse_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module fuse_ctl_regs_tb_top;

  localparam int NW  = 16;
  localparam int DW  = 32;
  localparam int AW  = 12;
  localparam int IW  = $clog2(NW);
  localparam int LAT = 4;
  localparam logic [31:0] KEYW = 32'h3E77_0000;
  localparam logic [31:0] BAD  = 32'hBADA_BADA;
  localparam logic [11:0] A_CTRL = 12'h000, A_SET = 12'h004, A_CLR = 12'h008, A_DATA = 12'h020;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0, busRdata, seqWdata, seqRdata;
  logic busRvalid, seqReq, seqOp, seqDone;
  logic [IW-1:0] seqAddr;

  always #4 clk = ~clk;

  fuse_ctl_regs #(.NUM_WORDS(NW), .DATA_W(DW), .BUS_AW(AW)) dut_i (
    .clk, .rstN, .busWe, .busRe, .busAddr, .busWdata, .busRdata, .busRvalid,
    .seqReq, .seqOp, .seqAddr, .seqWdata, .seqDone, .seqRdata
  );

  // Behavioural fuse array and sequencer
  logic [DW-1:0] fuse [NW];
  int cnt, progCount, readCount;
  logic mOp;
  logic [IW-1:0] mAddr, lastAddr;
  logic [DW-1:0] mData, lastData;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NW; i++) fuse[i] <= '0;
      cnt <= 0; seqDone <= 1'b0; seqRdata <= '0;
      progCount <= 0; readCount <= 0; mOp <= 1'b0; mAddr <= '0; mData <= '0;
      lastAddr <= '0; lastData <= '0;
    end else begin
      seqDone <= 1'b0;
      if (seqReq) begin
        cnt <= LAT; mOp <= seqOp; mAddr <= seqAddr; mData <= seqWdata;
      end else if (cnt == 1) begin
        cnt <= 0; seqDone <= 1'b1;
        if (mOp) begin
          seqRdata <= fuse[mAddr]; readCount <= readCount + 1;
        end else begin
          fuse[mAddr] <= fuse[mAddr] | mData; progCount <= progCount + 1;
          lastAddr <= mAddr; lastData <= mData;
        end
      end else if (cnt > 1) begin
        cnt <= cnt - 1;
      end
    end
  end

  // Scoreboard
  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (busRvalid) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read data: actual %h expected none", busRdata);
      end else begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (busRdata !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, busRdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); busRe = 1'b1; busAddr = a;
    it.exp = e; it.tag = tag; q.push_back(it);
    @(negedge clk); busRe = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] sh(input int n);
    return 12'(12'h400 + n * 16);
  endfunction

  function automatic logic [31:0] cw(input logic [7:0] a, input bit b, input bit e,
                                     input bit r, input bit k);
    return {k ? 16'h3E77 : 16'h0, 5'b0, r, e, b, a};
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(5); rstN = 1'b1; idle(2);

    rd(A_CTRL, 32'h0, "R1 ctrl reset");
    rd(A_DATA, 32'h0, "R1 data reset");
    rd(sh(0), 32'h0, "R1 shadow0 reset");
    rd(sh(15), 32'h0, "R1 shadow15 reset");

    wr(A_CTRL, 32'h5A);        rd(A_CTRL, 32'h5A, "R2 direct write");
    wr(A_SET, 32'h81);         rd(A_SET, 32'hDB, "R2 set alias");
    wr(A_CLR, 32'h0F);         rd(A_CLR, 32'hD0, "R2 clear alias");
    wr(A_SET, KEYW);           rd(A_CTRL, cw(8'hD0,0,0,0,1), "R2 key field");
    wr(A_CTRL, 32'h0);         rd(A_CTRL, 32'h0, "R2 key disarm");

    wr(A_CTRL, 32'h3); wr(A_DATA, 32'h1234);
    rd(A_CTRL, cw(8'h3,0,0,0,0), "R3 no busy without key");
    rd(A_DATA, 32'h1234, "R3 data stored");
    idle(20); chk("R3 no program request", progCount, 0);

    wr(A_CTRL, KEYW | 32'h2);  rd(A_CTRL, cw(8'h2,0,0,0,1), "R4 armed");
    wr(A_DATA, 32'hF0);        rd(A_CTRL, cw(8'h2,1,0,0,0), "R4 busy and key cleared");
    wr(A_CTRL, 32'h7);         rd(A_CTRL, cw(8'h7,1,0,0,0), "R4 address rewritten in flight");
    idle(20);
    rd(A_CTRL, cw(8'h7,0,0,0,0), "R4 busy cleared");
    chk("R4 latched address", 32'(lastAddr), 32'h2);
    chk("R4 program data", lastData, 32'hF0);
    rd(sh(2), 32'h0, "R11 shadow unchanged before reload");

    wr(A_CTRL, KEYW | 32'h4); wr(A_DATA, 32'hAAAA_0000); wr(A_DATA, 32'h5555);
    rd(A_CTRL, cw(8'h4,1,1,0,0), "R5 error on busy data write");
    rd(A_DATA, 32'hAAAA_0000, "R5 data frozen");
    idle(20);
    chk("R5 programmed data", lastData, 32'hAAAA_0000);
    rd(A_CTRL, cw(8'h4,0,1,0,0), "R5 error sticky");
    wr(A_CLR, 32'h200);        rd(A_CTRL, cw(8'h4,0,0,0,0), "R10 error cleared");

    wr(A_SET, 32'h400);        rd(A_CTRL, cw(8'h4,1,0,1,0), "R7 reload running");
    idle(200);
    rd(A_CTRL, cw(8'h4,0,0,0,0), "R7 reload self-clear");
    chk("R7 all words read", readCount, NW);
    rd(sh(2), 32'hF0, "R11 shadow after reload");
    rd(sh(4), 32'hAAAA_0000, "R11 shadow4 after reload");
    rd(sh(3), 32'h0, "R7 untouched word");

    wr(sh(5), 32'h11);         rd(sh(5), 32'h11, "R9 shadow write");
    wr(A_SET, 32'h400); wr(sh(6), 32'h22);
    idle(200);
    rd(A_CTRL, cw(8'h4,0,1,0,0), "R9 error on write during reload");
    wr(A_CLR, 32'h200);
    rd(sh(6), 32'h0, "R9 shadow kept during reload");

    wr(A_CTRL, KEYW | 32'hF); wr(A_DATA, 32'h0008_0102); idle(20);
    wr(A_SET, 32'h400); idle(200);
    rd(A_CTRL, cw(8'hF,0,0,0,0), "R7 lock reload done");
    rd(sh(15), 32'h0008_0102, "R7 lock word shadow");

    wr(A_CTRL, KEYW | 32'h1); wr(A_DATA, 32'h77);
    rd(A_CTRL, cw(8'h1,0,1,0,0), "R6 locked word refused");
    idle(20); chk("R6 no fuse access", progCount, 3);
    wr(A_CLR, 32'h200);
    wr(A_CTRL, KEYW | 32'h20); wr(A_DATA, 32'h77);
    rd(A_CTRL, cw(8'h20,0,1,0,0), "R6 out of range refused");
    idle(20); chk("R6 no fuse access range", progCount, 3);
    wr(A_CLR, 32'h200);

    rd(sh(3), BAD, "R8 read-locked sentinel");
    rd(A_CTRL, cw(8'h20,0,1,0,0), "R8 error set");
    wr(A_CLR, 32'h200);
    rd(sh(2), 32'hF0, "R8 unlocked word reads");

    wr(sh(8), 32'h99);
    rd(A_CTRL, cw(8'h20,0,1,0,0), "R9 write-locked shadow error");
    wr(A_CLR, 32'h200);
    rd(sh(8), 32'h0, "R9 write-locked shadow kept");

    wr(sh(5), 32'h55);         rd(sh(5), 32'h55, "R10 setup");
    rd(sh(3), BAD, "R10 raise error");
    wr(sh(5), 32'h66);
    wr(A_SET, 32'h400);
    rd(A_CTRL, cw(8'h20,0,1,0,0), "R10 reload ignored");
    wr(A_CTRL, KEYW | 32'h9); wr(A_DATA, 32'h1);
    rd(A_DATA, 32'h77, "R10 data write ignored");
    rd(A_CTRL, cw(8'h9,0,1,0,1), "R10 key kept");
    rd(sh(5), BAD, "R10 read under error");
    wr(A_CLR, 32'h200);
    rd(sh(5), 32'h55, "R10 shadow write ignored");
    chk("R10 no program under error", progCount, 3);

    wr(A_DATA, 32'h3); wr(A_SET, 32'h400);
    rd(A_CTRL, cw(8'h9,1,1,0,0), "R12 reload while busy");
    idle(20);
    rd(A_CTRL, cw(8'h9,0,1,0,0), "R12 program finished");
    chk("R12 program count", progCount, 4);
    chk("R12 program address", 32'(lastAddr), 32'h9);
    wr(A_CLR, 32'h200);
    rd(A_CTRL, cw(8'h9,0,0,0,0), "R12 clean");

    idle(5);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard drain: actual %0d expected 0", q.size());
    end
    summary();
  end

endmodule